// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache

This block sits between a processor request port and a slower, word-serial main-memory port. Each processor byte address is cut into four fields. From the least significant bit upward they are the byte offset, the block offset, the line index and the tag. The index picks exactly one line. That line's stored tag is compared with the address tag, and the result counts only if the line's valid flag is set. A hit is served straight from the cache array in the cycle of the request.

Writes that hit stay in the cache and mark the line dirty. Memory learns of them only when the line is evicted. On a miss the processor is held off. If the line in the way is dirty, its whole block is first copied out word by word to its own address. The block that contains the requested word is then read in, word by word. After that the original request completes as a hit. A write miss allocates the line in the same way and then merges the written word.

Line count, block length, word width and address width are parameters. The field widths follow from them.

Top module: `dmc_cache`

## Requirements
- R1: The byte address splits from bit 0 upward into byte offset (log2 of bytes per word), block offset (log2 of words per block), index (log2 of lines) and tag (all remaining bits). With the default geometry (12-bit address, 32-bit words, 2-word blocks, 8 lines) these are bits [1:0], [2], [5:3] and [11:6].
- R2: `cpu_hit` is 1 only when the line picked by the index is valid and its stored tag equals the address tag.
- R3: A read hit raises `cpu_ready` in the cycle of the request. It returns the addressed word on `cpu_rdata` and causes no memory traffic.
- R4: A write hit updates only the cache, makes no memory access and marks the line dirty.
- R5: A miss on a clean or invalid line performs no memory write. It reads exactly one block of words from memory, then completes the request.
- R6: A miss on a valid dirty line first writes all words of the victim block to memory at the victim's own address, then fetches the new block. No memory read occurs while the line is still dirty.
- R7: `cpu_ready` is low from the first cycle of a miss until the refill has completed. The processor holds its request, address and write data until `cpu_ready` is seen high.
- R8: A write miss fetches the block, merges the written word and leaves the line dirty. A later read returns the merged word.
- R9: Reset clears every valid and dirty flag. After reset every lookup misses and no write-back is made.
- R10: `mem_req` stays high with `mem_addr` and `mem_we` stable until `mem_ack` is returned. Each `mem_ack` transfers exactly one word.
- R11: With 7-bit addresses, 8 lines and 1-word blocks, the word-address sequence 0, 8, 0, 6, 8, 16 misses on all six accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address of the word |
| cpu_wdata | input | WORD_W | Write data |
| cpu_ready | output | 1 | Request completes at this clock edge |
| cpu_hit | output | 1 | Lookup result for cpu_addr |
| cpu_rdata | output | WORD_W | Read data, valid with cpu_ready |
| mem_req | output | 1 | Memory word transfer requested |
| mem_we | output | 1 | 1 = write to memory, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the memory word |
| mem_wdata | output | WORD_W | Word written to memory |
| mem_ack | input | 1 | One-cycle completion of a word transfer |
| mem_rdata | input | WORD_W | Read word, valid with mem_ack |

## Verification
The hardest situation to reach from the ports is a dirty line being evicted, followed by a re-read of the evicted address. Only that re-read shows whether the write-back stored the right words at the right address.

The stimulus reaches this state in two ways. Directed accesses write a line and then touch a conflicting tag at the same index. A seeded random stream, narrowed to four tags, then produces frequent conflicts. Each access is scored against a bench model of valid, tag and dirty state. That model predicts the hit result, the number of memory reads and the number of memory writes. A mid-run reset discards a dirty line, which confirms that no write-back follows.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WB   = 2'd1,
      ST_FILL = 2'd2
   } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
   parameter int LINES = 8,
   parameter int IDX_W = 3,
   parameter int TAG_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   input  logic             fill_done,
   input  logic             set_dirty,
   input  logic             clr_dirty,
   output logic             hit,
   output logic             victim_dirty,
   output logic [TAG_W-1:0] line_tag
);
   logic [LINES-1:0] valid_q;
   logic [LINES-1:0] dirty_q;
   logic [TAG_W-1:0] tag_q [LINES];

   always_comb begin
      line_tag     = tag_q[lk_idx];
      hit          = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
      victim_dirty = valid_q[lk_idx] && dirty_q[lk_idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else begin
         if (fill_done) begin
            valid_q[lk_idx] <= 1'b1;
            dirty_q[lk_idx] <= 1'b0;
         end else if (set_dirty) begin
            dirty_q[lk_idx] <= 1'b1;
         end else if (clr_dirty) begin
            dirty_q[lk_idx] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_done) tag_q[lk_idx] <= lk_tag;
   end

   // R4: a write hit leaves its line dirty
   a_r4_dirty_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      set_dirty |=> dirty_q[$past(lk_idx)]);
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
   parameter int WORD_W = 32,
   parameter int DA_W   = 4
) (
   input  logic              clk,
   input  logic              we,
   input  logic [DA_W-1:0]   waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [DA_W-1:0]   ra_addr,
   output logic [WORD_W-1:0] ra_data,
   input  logic [DA_W-1:0]   rb_addr,
   output logic [WORD_W-1:0] rb_data
);
   localparam int DEPTH = 1 << DA_W;
   logic [WORD_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   assign ra_data = mem_q[ra_addr];
   assign rb_data = mem_q[rb_addr];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
   import dmc_pkg::*;
#(
   parameter int BLOCK_WORDS = 2,
   parameter int CNT_W       = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             we,
   input  logic             hit,
   input  logic             victim_dirty,
   input  logic             mem_ack,
   output dmc_state_e       st,
   output logic [CNT_W-1:0] cnt,
   output logic             ready,
   output logic             wr_hit,
   output logic             fill_wr,
   output logic             fill_last,
   output logic             wb_last,
   output logic             mem_req,
   output logic             mem_we
);
   logic cnt_last;

   always_comb begin
      cnt_last  = (cnt == CNT_W'(BLOCK_WORDS - 1));
      ready     = (st == ST_IDLE) && req && hit;
      wr_hit    = ready && we;
      mem_req   = (st != ST_IDLE);
      mem_we    = (st == ST_WB);
      fill_wr   = (st == ST_FILL) && mem_ack;
      fill_last = fill_wr && cnt_last;
      wb_last   = (st == ST_WB) && mem_ack && cnt_last;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (req && !hit) begin
                  st  <= victim_dirty ? ST_WB : ST_FILL;
                  cnt <= '0;
               end
            end
            ST_WB: begin
               if (mem_ack) begin
                  if (cnt_last) begin
                     st  <= ST_FILL;
                     cnt <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_FILL: begin
               if (mem_ack) begin
                  if (cnt_last) st <= ST_IDLE;
                  else          cnt <= cnt + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
   import dmc_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int WORD_W      = 32,
   parameter int LINES       = 8,
   parameter int BLOCK_WORDS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic              cpu_hit,
   output logic [WORD_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata
);
   localparam int BYTE_OFF = $clog2(WORD_W / 8);
   localparam int OFF_LOG  = $clog2(BLOCK_WORDS);
   localparam int IDX_W    = $clog2(LINES);
   localparam int TAG_W    = ADDR_W - BYTE_OFF - OFF_LOG - IDX_W;
   localparam int CNT_W    = (OFF_LOG > 0) ? OFF_LOG : 1;
   localparam int DA_W     = IDX_W + OFF_LOG;

   if (WORD_W < 8 || (1 << $clog2(WORD_W)) != WORD_W) begin : g_chk_word
      $error("dmc_cache: WORD_W must be a power of two, at least 8");
   end
   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_chk_lines
      $error("dmc_cache: LINES must be a power of two, at least 2");
   end
   if (BLOCK_WORDS < 1 || (1 << OFF_LOG) != BLOCK_WORDS) begin : g_chk_block
      $error("dmc_cache: BLOCK_WORDS must be a power of two");
   end
   if (TAG_W < 1) begin : g_chk_tag
      $error("dmc_cache: ADDR_W leaves no tag bits");
   end

   logic [IDX_W-1:0] idx;
   logic [TAG_W-1:0] tag;
   logic [TAG_W-1:0] line_tag;
   logic [TAG_W-1:0] tag_sel;
   logic [DA_W-1:0]  cpu_da;
   logic [DA_W-1:0]  cnt_da;
   logic [CNT_W-1:0] cnt;
   dmc_state_e       st;
   logic hit, victim_dirty, wr_hit, fill_wr, fill_last, wb_last;
   logic             dwe;
   logic [DA_W-1:0]  dwaddr;
   logic [WORD_W-1:0] dwdata;
   logic unused_byte_bits;

   assign idx     = cpu_addr[BYTE_OFF + OFF_LOG +: IDX_W];
   assign tag     = cpu_addr[ADDR_W-1 -: TAG_W];
   assign tag_sel = (st == ST_WB) ? line_tag : tag;
   assign unused_byte_bits = ^cpu_addr[BYTE_OFF-1:0];

   if (OFF_LOG > 0) begin : g_multi_word
      logic [OFF_LOG-1:0] off;
      assign off      = cpu_addr[BYTE_OFF +: OFF_LOG];
      assign cpu_da   = {idx, off};
      assign cnt_da   = {idx, cnt};
      assign mem_addr = {tag_sel, idx, cnt, {BYTE_OFF{1'b0}}};
   end else begin : g_single_word
      logic unused_cnt_bits;
      assign unused_cnt_bits = ^cnt;
      assign cpu_da   = idx;
      assign cnt_da   = idx;
      assign mem_addr = {tag_sel, idx, {BYTE_OFF{1'b0}}};
   end

   dmc_ctrl #(
      .BLOCK_WORDS(BLOCK_WORDS),
      .CNT_W      (CNT_W)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req         (cpu_req),
      .we          (cpu_we),
      .hit         (hit),
      .victim_dirty(victim_dirty),
      .mem_ack     (mem_ack),
      .st          (st),
      .cnt         (cnt),
      .ready       (cpu_ready),
      .wr_hit      (wr_hit),
      .fill_wr     (fill_wr),
      .fill_last   (fill_last),
      .wb_last     (wb_last),
      .mem_req     (mem_req),
      .mem_we      (mem_we)
   );

   dmc_tag_store #(
      .LINES(LINES),
      .IDX_W(IDX_W),
      .TAG_W(TAG_W)
   ) u_tags (
      .clk         (clk),
      .rst_n       (rst_n),
      .lk_idx      (idx),
      .lk_tag      (tag),
      .fill_done   (fill_last),
      .set_dirty   (wr_hit),
      .clr_dirty   (wb_last),
      .hit         (hit),
      .victim_dirty(victim_dirty),
      .line_tag    (line_tag)
   );

   assign dwe    = wr_hit || fill_wr;
   assign dwaddr = fill_wr ? cnt_da : cpu_da;
   assign dwdata = fill_wr ? mem_rdata : cpu_wdata;

   dmc_data_store #(
      .WORD_W(WORD_W),
      .DA_W  (DA_W)
   ) u_data (
      .clk    (clk),
      .we     (dwe),
      .waddr  (dwaddr),
      .wdata  (dwdata),
      .ra_addr(cpu_da),
      .ra_data(cpu_rdata),
      .rb_addr(cnt_da),
      .rb_data(mem_wdata)
   );

   assign cpu_hit = hit;

   // R6: the new block is never fetched over a line that is still dirty
   a_r6_no_fill_over_dirty: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> !victim_dirty);

   // R10: a pending memory transfer keeps its request, address and direction
   a_r10_mem_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R7: once the refill ends, a held request completes in the next cycle
   a_r7_ready_after_refill: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_last && cpu_req) |=> (cpu_ready || !cpu_req || !$stable(cpu_addr)));

   // R2: a lookup on a line that was just refilled reports a hit
   a_r2_hit_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
      fill_last |=> (cpu_hit || !$stable(cpu_addr)));
endmodule

// File: tb/dmc_mem_model.sv
module dmc_mem_model #(
   parameter int AW  = 12,
   parameter int LAT = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [31:0]   wdata,
   output logic          ack,
   output logic [31:0]   rdata,
   output int unsigned   rd_cnt,
   output int unsigned   wr_cnt
);
   localparam int WORDS = 1 << (AW - 2);
   logic [31:0] mem [WORDS];
   int unsigned wait_q;

   function automatic logic [31:0] seed_word(input int unsigned w);
      return 32'hC0DE_0000 ^ (w * 32'h0001_0203);
   endfunction

   initial begin
      for (int i = 0; i < WORDS; i++) mem[i] = seed_word(i);
      rd_cnt = 0;
      wr_cnt = 0;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         ack    <= 1'b0;
         wait_q <= 0;
      end else begin
         ack <= 1'b0;
         if (req && !ack) begin
            if (wait_q == LAT) begin
               ack    <= 1'b1;
               rdata  <= mem[addr[AW-1:2]];
               wait_q <= 0;
               if (we) begin
                  mem[addr[AW-1:2]] <= wdata;
                  wr_cnt <= wr_cnt + 1;
               end else begin
                  rd_cnt <= rd_cnt + 1;
               end
            end else begin
               wait_q <= wait_q + 1;
            end
         end
      end
   end
endmodule

// File: tb/dmc_cache_bench.sv
module dmc_cache_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW    = 12;
   localparam int LINES = 8;
   localparam int BW    = 2;
   localparam int LOW   = 3;   // byte offset + block offset bits
   localparam int IW    = 3;
   localparam int WORDS = 1 << (AW - 2);
   localparam int SAW   = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   // main instance
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [31:0]   cpu_wdata = '0;
   logic          cpu_ready, cpu_hit;
   logic [31:0]   cpu_rdata;
   logic          mem_req, mem_we, mem_ack;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata, mem_rdata;
   int unsigned   rd_cnt, wr_cnt;

   dmc_cache #(.ADDR_W(AW), .WORD_W(32), .LINES(LINES), .BLOCK_WORDS(BW)) u_dmc_cache (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata));

   dmc_mem_model #(.AW(AW), .LAT(2)) u_mem (
      .clk(clk), .rst_n(rst_n), .req(mem_req), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata),
      .ack(mem_ack), .rdata(mem_rdata), .rd_cnt(rd_cnt), .wr_cnt(wr_cnt));

   // small instance: 7-bit address, 8 lines, 1-word blocks
   logic           s_req = 1'b0;
   logic [SAW-1:0] s_addr = '0;
   logic           s_ready, s_hit, s_mreq, s_mwe, s_mack;
   logic [31:0]    s_rdata, s_mwdata, s_mrdata;
   logic [SAW-1:0] s_maddr;
   int unsigned    s_rd, s_wr;

   dmc_cache #(.ADDR_W(SAW), .WORD_W(32), .LINES(8), .BLOCK_WORDS(1)) u_dmc_cache_small (
      .clk(clk), .rst_n(rst_n), .cpu_req(s_req), .cpu_we(1'b0), .cpu_addr(s_addr),
      .cpu_wdata(32'h0), .cpu_ready(s_ready), .cpu_hit(s_hit), .cpu_rdata(s_rdata),
      .mem_req(s_mreq), .mem_we(s_mwe), .mem_addr(s_maddr), .mem_wdata(s_mwdata),
      .mem_ack(s_mack), .mem_rdata(s_mrdata));

   dmc_mem_model #(.AW(SAW), .LAT(1)) u_mem_small (
      .clk(clk), .rst_n(rst_n), .req(s_mreq), .we(s_mwe), .addr(s_maddr), .wdata(s_mwdata),
      .ack(s_mack), .rdata(s_mrdata), .rd_cnt(s_rd), .wr_cnt(s_wr));

   int n_chk = 0;
   int n_bad = 0;
   logic        exp_v [LINES];
   logic        exp_d [LINES];
   int unsigned exp_t [LINES];
   logic [31:0] shadow [WORDS];

   function automatic logic [31:0] seed_word(input int unsigned w);
      return 32'hC0DE_0000 ^ (w * 32'h0001_0203);
   endfunction
   function automatic int unsigned f_idx(input logic [AW-1:0] a);
      return (int'(a) >> LOW) % LINES;
   endfunction
   function automatic int unsigned f_tag(input logic [AW-1:0] a);
      return int'(a) >> (LOW + IW);
   endfunction
   function automatic logic [AW-1:0] mk_addr(input int unsigned t, input int unsigned i,
                                             input int unsigned o);
      return AW'((t << (LOW + IW)) | (i << LOW) | (o << 2));
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic model_clear();
      for (int i = 0; i < LINES; i++) begin
         exp_v[i] = 1'b0; exp_d[i] = 1'b0; exp_t[i] = 0;
      end
   endtask

   task automatic access(input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                         input string rq);
      int unsigned i, t, r0, w0, erd, ewr, n;
      logic eh;
      logic [31:0] got;
      i = f_idx(a); t = f_tag(a);
      eh  = exp_v[i] && (exp_t[i] == t);
      erd = eh ? 0 : BW;
      ewr = (!eh && exp_v[i] && exp_d[i]) ? BW : 0;
      r0 = rd_cnt; w0 = wr_cnt;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = w; cpu_addr = a; cpu_wdata = d;
      #1;
      chk(cpu_hit == eh, "R2 hit", 32'(cpu_hit), 32'(eh));
      if (!eh) chk(cpu_ready == 1'b0, "R7 ready in miss cycle", 32'(cpu_ready), 32'h0);
      n = 0;
      while (!cpu_ready && n < 200) begin
         @(negedge clk); #1; n++;
      end
      chk(cpu_ready == 1'b1, "R7 completion", 32'(cpu_ready), 32'h1);
      got = cpu_rdata;
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0;
      if (!w) chk(got == shadow[a[AW-1:2]], rq, got, shadow[a[AW-1:2]]);
      chk((rd_cnt - r0) == erd, "R5 memory reads", rd_cnt - r0, erd);
      chk((wr_cnt - w0) == ewr, (ewr != 0) ? "R6 write-back words" : "R4 no memory write",
          wr_cnt - w0, ewr);
      if (w) shadow[a[AW-1:2]] = d;
      exp_d[i] = w ? 1'b1 : (eh ? exp_d[i] : 1'b0);
      exp_v[i] = 1'b1;
      exp_t[i] = t;
   endtask

   task automatic small_read(input int unsigned waddr);
      int n;
      @(negedge clk);
      s_req = 1'b1; s_addr = SAW'(waddr << 2);
      #1;
      chk(s_hit == 1'b0, "R11 expected miss", 32'(s_hit), 32'h0);
      n = 0;
      while (!s_ready && n < 100) begin
         @(negedge clk); #1; n++;
      end
      chk(s_ready && s_rdata == seed_word(waddr), "R11 data", s_rdata, seed_word(waddr));
      @(negedge clk);
      s_req = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
      $finish;
   end

   initial begin
      int unsigned seed_dummy, w0, r0;
      seed_dummy = $urandom(32'h5EED_0042);
      for (int k = 0; k < WORDS; k++) shadow[k] = seed_word(k);
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(!cpu_ready && !mem_req, "R9 idle after reset", {cpu_ready, mem_req}, 32'h0);

      // R1/R5: clean miss then a hit on the other word of the same block
      access(1'b0, mk_addr(1, 2, 0), 32'h0, "R5 read miss data");
      access(1'b0, mk_addr(1, 2, 1), 32'h0, "R1 block offset selects word");
      access(1'b0, mk_addr(1, 3, 0), 32'h0, "R1 index separates lines");
      // R3/R4: write hit then read hit
      access(1'b1, mk_addr(1, 2, 1), 32'hDEAD_BEEF, "R4");
      access(1'b0, mk_addr(1, 2, 1), 32'h0, "R3 read hit after write");
      // R6: conflicting tag evicts the dirty line, then the old data returns
      access(1'b0, mk_addr(2, 2, 0), 32'h0, "R6 new block data");
      access(1'b0, mk_addr(1, 2, 1), 32'h0, "R6 written-back word");
      // R8: write miss allocates and merges
      access(1'b1, mk_addr(3, 5, 0), 32'h1234_5678, "R8");
      access(1'b0, mk_addr(3, 5, 0), 32'h0, "R8 merged word");
      access(1'b0, mk_addr(3, 5, 1), 32'h0, "R8 neighbour word fetched");
      access(1'b0, mk_addr(0, 5, 1), 32'h0, "R8 dirty eviction data");

      // random mix with narrow tag range
      for (int k = 0; k < 300; k++) begin
         logic [AW-1:0] ra;
         ra = mk_addr($urandom % 4, $urandom % LINES, $urandom % BW);
         access(1'(($urandom % 3) == 0), ra, $urandom, "R3 random read data");
      end

      // R9: reset discards a dirty line without write-back
      access(1'b1, mk_addr(2, 0, 0), 32'hFACE_0001, "R9");
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_clear();
      for (int k = 0; k < WORDS; k++) shadow[k] = u_mem.mem[k];
      w0 = wr_cnt; r0 = rd_cnt;
      access(1'b0, mk_addr(1, 0, 0), 32'h0, "R9 read after reset");
      chk(wr_cnt == w0, "R9 no write-back after reset", wr_cnt - w0, 32'h0);
      chk(rd_cnt - r0 == BW, "R9 refill after reset", rd_cnt - r0, BW);

      // R11: reference sequence on the small geometry
      small_read(0); small_read(8); small_read(0);
      small_read(6); small_read(8); small_read(16);
      chk(s_wr == 0, "R11 no writes", s_wr, 32'h0);
      chk(s_rd == 6, "R11 six refills", s_rd, 32'd6);

      report();
      $finish;
   end
endmodule